// File: doc/BRIEF.md
# Grouped Pairwise Core Comparator Self-Test

This block runs a built-in self-test over a bank of identical arithmetic cores without needing a known-good reference core. The cores are split into groups of four. During a test run the block drives one shared stimulus word to every core. For each group it compares all six pairings of core outputs on every cycle.

A comparison bit is sticky for the whole run. When the run ends, the six bits of each group are decoded into a mask of faulty cores. The decode can name up to two bad cores per group in a single pass, with no reconfiguration. Groups whose disagreement pattern cannot be explained are flagged instead. The stimulus is a free-running counter that covers the full operand space once; each half of the counter is one multiplier operand.

Top module: `pairgrp_bist`

## Requirements
- R1: After reset, busy, done, every comparison bit, every fault-map bit and every undiagnosable flag are 0, and the stimulus output is 0.
- R2: A start pulse clears all comparison bits, sets the stimulus to 0, raises busy and lowers done on the next clock edge. A start pulse also restarts a run already in progress.
- R3: While busy, the stimulus advances by one per clock. A run lasts exactly 2^STIM_W cycles, where STIM_W = 2*OP_W, after which busy falls and done rises; done then holds until the next start.
- R4: Comparison bit g*6+k covers group g, whose cores are g*4..g*4+3. The pairs by k are 0:(0,1), 1:(0,2), 2:(0,3), 3:(1,2), 4:(1,3) and 5:(2,3). A bit is 1 when its two cores' outputs differed in at least one cycle of the run, even if they agreed on every other stimulus.
- R5: Once a run has finished, changes on the core outputs do not alter the comparison bits, the fault map or the undiagnosable flags.
- R6: If a group has exactly three mismatching pairs and they all involve one core, that core's fault-map bit (bit c for core c) is 1 and the group's undiagnosable flag is 0.
- R7: If a group has five mismatching pairs, so that exactly one pair agrees, the two cores outside that pair are marked faulty and the flag stays 0.
- R8: Any other non-zero mismatch pattern in a group sets that group's undiagnosable flag and leaves its fault-map bits at 0. Examples are two faulty cores that give identical wrong outputs, or three faulty cores.
- R9: A group with no mismatches reports no faulty cores and no flag, whatever the other groups report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new test run |
| core_out | input | GROUPS*4*2*OP_W | Output word of each core, core c at bits c*W upward |
| stim | output | 2*OP_W | Shared stimulus, upper half is operand A, lower half operand B |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| cmp_bits | output | GROUPS*6 | Sticky pairwise mismatch bits |
| fault_map | output | GROUPS*4 | One bit per core, 1 = diagnosed faulty |
| undiag | output | GROUPS | One bit per group, 1 = pattern not decodable |

## Verification
A corrupted sticky bit shows on cmp_bits as soon as the edge that corrupts it has passed, and in the same cycle it moves fault_map or undiag for its own group only. The bench therefore predicts every group's six bits by sweeping the stimulus space against its own core model. It mixes clean groups, a single stuck core, two unequal faulty cores, two equal faulty cores and three faulty cores in one run, so that a slip in pair ordering or decode shows up in a neighbouring group. A counter fault shows in the run length and in the stimulus sequence seen at the port. A leak after the run shows within a few cycles, once the injected faults are removed.

// File: rtl/pairgrp_bist.sv
module pairgrp_bist #(
  parameter int OP_W   = 8,
  parameter int GROUPS = 8,
  localparam int W      = 2 * OP_W,
  localparam int STIM_W = 2 * OP_W,
  localparam int CORES  = GROUPS * 4,
  localparam int NCMP   = GROUPS * 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CORES*W-1:0]  core_out,
  output logic [STIM_W-1:0]   stim,
  output logic                busy,
  output logic                done,
  output logic [NCMP-1:0]     cmp_bits,
  output logic [CORES-1:0]    fault_map,
  output logic [GROUPS-1:0]   undiag
);

  function automatic int lo_of(input int k);
    case (k)
      0, 1, 2: return 0;
      3, 4:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic int hi_of(input int k);
    case (k)
      0:       return 1;
      1, 3:    return 2;
      default: return 3;
    endcase
  endfunction

  logic [STIM_W-1:0] cnt;
  logic              run, fin;
  logic [NCMP-1:0]   seen, diff;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar k = 0; k < 6; k++) begin : g_pair
      localparam int A = g * 4 + lo_of(k);
      localparam int B = g * 4 + hi_of(k);
      assign diff[g*6+k] = core_out[A*W +: W] != core_out[B*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      run  <= 1'b0;
      fin  <= 1'b0;
      seen <= '0;
    end else if (start) begin
      cnt  <= '0;
      run  <= 1'b1;
      fin  <= 1'b0;
      seen <= '0;
    end else if (run) begin
      seen <= seen | diff;
      cnt  <= cnt + 1'b1;
      if (&cnt) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_dec
    logic [5:0] m;
    logic [3:0] all3;
    int         nmm;
    logic       one_bad, two_bad;

    assign m = seen[g*6 +: 6];

    always_comb begin
      all3[0] = m[0] & m[1] & m[2];
      all3[1] = m[0] & m[3] & m[4];
      all3[2] = m[1] & m[3] & m[5];
      all3[3] = m[2] & m[4] & m[5];
      nmm     = $countones(m);
      one_bad = (nmm == 3) && ($countones(all3) == 1);
      two_bad = (nmm == 5);
    end

    assign fault_map[g*4 +: 4] = (one_bad || two_bad) ? all3 : 4'b0000;
    assign undiag[g]           = (nmm != 0) && !one_bad && !two_bad;
  end

  assign stim     = cnt;
  assign busy     = run;
  assign done     = fin;
  assign cmp_bits = seen;

endmodule

// File: rtl/pairgrp_bist_chk.sv
module pairgrp_bist_chk #(
  parameter int GROUPS = 8,
  parameter int STIM_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [STIM_W-1:0]   stim,
  input logic                busy,
  input logic                done,
  input logic [GROUPS*6-1:0] cmp_bits,
  input logic [GROUPS*4-1:0] fault_map,
  input logic [GROUPS-1:0]   undiag
);

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R3

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && cmp_bits == '0 && stim == '0)); // R2

  AST_STIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (stim == STIM_W'($past(stim) + 1'b1))); // R3

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R3

  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (($past(cmp_bits) & ~cmp_bits) == '0)); // R4

  AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cmp_bits) && $stable(fault_map) && $stable(undiag))); // R5

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    AST_MAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(fault_map[g*4 +: 4]) <= 2); // R7

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(undiag[g] && (|fault_map[g*4 +: 4]))); // R8

    AST_CLEAN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_bits[g*6 +: 6] == 6'b0) |-> (fault_map[g*4 +: 4] == 4'b0 && !undiag[g])); // R9
  end

endmodule

bind pairgrp_bist pairgrp_bist_chk #(.GROUPS(GROUPS), .STIM_W(STIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stim(stim), .busy(busy), .done(done),
  .cmp_bits(cmp_bits), .fault_map(fault_map), .undiag(undiag)
);

// File: tb/pairgrp_bist_test.sv
module pairgrp_bist_test;
  localparam int OP_W   = 4;
  localparam int GROUPS = 8;
  localparam int W      = 2 * OP_W;
  localparam int SW     = 2 * OP_W;
  localparam int CORES  = GROUPS * 4;
  localparam int NCMP   = GROUPS * 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CORES*W-1:0] core_out;
  logic [SW-1:0]      stim;
  logic               busy, done;
  logic [NCMP-1:0]    cmp_bits;
  logic [CORES-1:0]   fault_map;
  logic [GROUPS-1:0]  undiag;

  logic [W-1:0] or_m  [CORES];
  logic [W-1:0] and_m [CORES];

  int checks = 0;
  int fails  = 0;

  logic [NCMP-1:0]   q_cmp [$];
  logic [CORES-1:0]  q_map [$];
  logic [GROUPS-1:0] q_und [$];
  string             q_tag [$];

  always #4 clk = ~clk;

  pairgrp_bist #(.OP_W(OP_W), .GROUPS(GROUPS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .core_out(core_out), .stim(stim),
    .busy(busy), .done(done), .cmp_bits(cmp_bits), .fault_map(fault_map), .undiag(undiag)
  );

  function automatic logic [W-1:0] model(input int c, input logic [SW-1:0] s);
    logic [W-1:0] p;
    p = W'(s[SW-1:OP_W]) * W'(s[OP_W-1:0]);
    return (p | or_m[c]) & ~and_m[c];
  endfunction

  always_comb begin
    for (int c = 0; c < CORES; c++)
      core_out[c*W +: W] = ((W'(stim[SW-1:OP_W]) * W'(stim[OP_W-1:0])) | or_m[c]) & ~and_m[c];
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NCMP-1:0] expect_cmp();
    int pl [6] = '{0, 0, 0, 1, 1, 2};
    int ph [6] = '{1, 2, 3, 2, 3, 3};
    logic [NCMP-1:0] r = '0;
    for (int g = 0; g < GROUPS; g++)
      for (int k = 0; k < 6; k++)
        for (int s = 0; s < (1 << SW); s++)
          if (model(g*4+pl[k], SW'(s)) != model(g*4+ph[k], SW'(s))) r[g*6+k] = 1'b1;
    return r;
  endfunction

  task automatic clear_faults();
    for (int c = 0; c < CORES; c++) begin
      or_m[c]  = '0;
      and_m[c] = '0;
    end
  endtask

  task automatic run_test(input string tag, input logic [CORES-1:0] emap, input logic [GROUPS-1:0] eund);
    int n = 0;
    int bad_step = 0;
    q_cmp.push_back(expect_cmp());
    q_map.push_back(emap);
    q_und.push_back(eund);
    q_tag.push_back(tag);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check("R2 busy after start", 64'(busy), 64'(1));
    check("R2 cleared bits", 64'(cmp_bits), 64'(0));
    check("R2 stim zero", 64'(stim), 64'(0));
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
      if (!done && stim != SW'(n)) bad_step++;
    end
    check("R3 run length", 64'(n), 64'(1 << SW));
    check("R3 stim steps", 64'(bad_step), 64'(0));
    check("R3 busy low at end", 64'(busy), 64'(0));
    @(negedge clk);
  endtask

  logic done_q = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (done && !done_q && q_tag.size() > 0) begin
        logic [NCMP-1:0]   ec;
        logic [CORES-1:0]  em;
        logic [GROUPS-1:0] eu;
        string             t;
        ec = q_cmp.pop_front();
        em = q_map.pop_front();
        eu = q_und.pop_front();
        t  = q_tag.pop_front();
        check({"R4 pair bits ", t}, 64'(cmp_bits), 64'(ec));
        check({"R6/R7/R9 fault map ", t}, 64'(fault_map), 64'(em));
        check({"R8 undiag ", t}, 64'(undiag), 64'(eu));
      end
      done_q = done;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [NCMP-1:0] held;
    clear_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", 64'(busy), 64'(0));
    check("R1 done", 64'(done), 64'(0));
    check("R1 bits", 64'(cmp_bits), 64'(0));
    check("R1 map", 64'(fault_map), 64'(0));
    check("R1 undiag", 64'(undiag), 64'(0));
    check("R1 stim", 64'(stim), 64'(0));

    run_test("clean", '0, '0);

    // single stuck-1 on core 2; cores 13,15 unequal faults; 22,23 identical; 28,29,30 all faulty
    or_m[2]   = 8'h01;
    or_m[13]  = 8'h01;
    and_m[15] = 8'h80;
    or_m[22]  = 8'h02;
    or_m[23]  = 8'h02;
    or_m[28]  = 8'h01;
    or_m[29]  = 8'h02;
    or_m[30]  = 8'h04;
    run_test("mixed", 32'h0000_A004, 8'hA0);
    held = expect_cmp();

    clear_faults();
    repeat (10) @(negedge clk);
    check("R5 bits frozen", 64'(cmp_bits), 64'(held));
    check("R5 map frozen", 64'(fault_map), 64'h0000_A004);
    check("R5 undiag frozen", 64'(undiag), 64'hA0);
    check("R3 done held", 64'(done), 64'(1));

    and_m[28] = 8'h01;
    or_m[5]   = 8'h01;
    or_m[7]   = 8'h01;
    run_test("rerun", 32'h1000_0000, 8'h02);

    clear_faults();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    run_test("restart", '0, '0);

    repeat (4) @(negedge clk);
    check("R3 queue drained", 64'(q_tag.size()), 64'(0));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule